// File: doc/BRIEF.md
# Master-Mode Serial Audio Clock Generator

This block generates the two serial audio clocks that a converter drives when it owns the link. From a master clock it makes a bit clock at 64 times the sample rate and a frame clock at the sample rate. A two-bit select field states the ratio of the master clock to the sample rate. A range input tells the block that the link runs in the high sample-rate band, where only the smallest ratio can be used.

Both clocks are made by registers in the master-clock domain. The block also gives two one-cycle strobes for a serial data formatter in the same domain. One marks every falling edge of the bit clock, where the formatter shifts out its next bit. The other marks the start of each frame. A select code that is not allowed, or a code that the high range does not permit, raises an error flag and holds both clocks low. When the setting changes, every counter starts again from zero, so the outputs are irregular for as short a time as possible.

Top module: `sclk_master_gen`

## Requirements
- R1: The select field sets the number of master-clock cycles in one bit-clock period: code 00 gives 4 (256x), code 01 gives 8 (512x) and code 10 gives 6 (384x). After reset the block behaves as code 00.
- R2: Code 11 is illegal. While it is applied, `cfg_err` is 1, `bclk` and `lrclk` stay 0, and neither strobe pulses.
- R3: With `hi_rate` = 1, only code 00 is legal. Codes 01 and 10 then behave as in R2, and code 00 runs with a 4-cycle bit clock and `cfg_err` = 0.
- R4: In each bit-clock period of N master cycles, `bclk` is 1 for exactly N/2 cycles and 0 for N/2 cycles.
- R5: `bclk_fall` is 1 for exactly the master cycles in which `bclk` has just changed from 1 to 0, which is once per bit-clock period.
- R6: One `lrclk` period is 64 bit-clock periods: 0 for 32 of them, then 1 for 32. Every change of `lrclk` happens in a cycle in which `bclk_fall` is 1.
- R7: `frame_start` is 1 for one cycle per frame. It comes with the bit-clock fall at which `lrclk` returns to 0.
- R8: A change of `ratio_sel` or `hi_rate` clears both clocks at the next master edge, and `cfg_err` takes the new legality at that edge. For a legal setting, the first `bclk_fall` and `frame_start` follow N+1 master edges after the new value is driven.
- R9: Synchronous active-high reset sets `bclk`, `lrclk`, both strobes and `cfg_err` to 0. With code 00 applied, the first bit-clock fall and frame start come on the 4th master edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register uses this clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Ratio select: 00=256x, 01=512x, 10=384x, 11=illegal |
| hi_rate | input | 1 | 1 when the sample rate is in the high band |
| bclk | output | 1 | Bit clock, 64 periods per frame |
| lrclk | output | 1 | Frame clock, 0 in the first half of the frame |
| bclk_fall | output | 1 | One-cycle strobe when the bit clock falls |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |
| cfg_err | output | 1 | Current setting is illegal |

## Verification
Each output comes from a register. After the inputs are driven, `cfg_err` and the cleared clocks are due one master edge later. The first bit-clock fall and frame start are due N+1 edges later, because the restart edge leaves the divide counter at zero and N more edges pass before it wraps. The bench drives on the falling master edge and samples on the next falling edge, one or more edges later. It checks exactly those latencies. It then counts high cycles, falls and frame starts over a window of exactly one frame, starting at the sampled frame start.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int unsigned RATIO_X256 = 256;
    localparam int unsigned RATIO_X384 = 384;
    localparam int unsigned RATIO_X512 = 512;
    localparam int unsigned RATIO_MAX  = RATIO_X512;

    typedef enum logic [1:0] {
        SEL_X256 = 2'b00,
        SEL_X512 = 2'b01,
        SEL_X384 = 2'b10,
        SEL_BAD  = 2'b11
    } ratio_sel_e;

    typedef struct packed {
        ratio_sel_e sel;
        logic       fast;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{sel: SEL_X256, fast: 1'b0};

    // True when the ratio is allowed in the selected rate band.
    function automatic logic cfg_legal(clk_cfg_t c);
        case (c.sel)
            SEL_X256:           return 1'b1;
            SEL_X512, SEL_X384: return !c.fast;
            default:            return 1'b0;
        endcase
    endfunction

    function automatic int unsigned ratio_of(ratio_sel_e s);
        case (s)
            SEL_X256: return RATIO_X256;
            SEL_X512: return RATIO_X512;
            SEL_X384: return RATIO_X384;
            default:  return 0;
        endcase
    endfunction

    // Master cycles per bit-clock period.
    function automatic int unsigned div_of(ratio_sel_e s, int unsigned bits_per_frame);
        return ratio_of(s) / bits_per_frame;
    endfunction

endpackage

// File: rtl/sclk_cfg_track.sv
module sclk_cfg_track
    import sclk_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned CNT_W          = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       sel_in,
    input  logic             fast_in,
    output logic             restart,
    output logic             run,
    output logic             err,
    output logic [CNT_W-1:0] div
);

    clk_cfg_t cfg_in;
    clk_cfg_t cfg_q;
    logic     legal_q;

    always_comb begin
        cfg_in.sel  = ratio_sel_e'(sel_in);
        cfg_in.fast = fast_in;
    end

    // Any change of the setting restarts both dividers.
    assign restart = (cfg_in != cfg_q);
    assign run     = legal_q && !restart;
    assign err     = !legal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            legal_q <= 1'b1;
            div     <= CNT_W'(div_of(SEL_X256, BITS_PER_FRAME));
        end else begin
            cfg_q   <= cfg_in;
            legal_q <= cfg_legal(cfg_in);
            div     <= CNT_W'(div_of(cfg_in.sel, BITS_PER_FRAME));
        end
    end

endmodule

// File: rtl/sclk_bit_div.sv
module sclk_bit_div #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    output logic             fall_tick,
    output logic             bclk,
    output logic             bclk_fall
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] half;

    always_comb begin
        half      = div >> 1;
        cnt_n     = (cnt == div - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
        fall_tick = run && (cnt_n == '0);
    end

    // Low while the count is in the lower half of the period, high in the upper half.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt       <= '0;
            bclk      <= 1'b0;
            bclk_fall <= 1'b0;
        end else begin
            cnt       <= cnt_n;
            bclk      <= (cnt_n >= half);
            bclk_fall <= (cnt_n == '0);
        end
    end

endmodule

// File: rtl/sclk_frame_div.sv
module sclk_frame_div #(
    parameter int unsigned BITS_PER_FRAME = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fall_tick,
    output logic lrclk,
    output logic frame_start
);

    localparam int unsigned FC_W = $clog2(BITS_PER_FRAME);

    logic [FC_W-1:0] fcnt;
    logic [FC_W-1:0] fcnt_n;

    assign fcnt_n = fcnt + FC_W'(1);

    // The count parks at all-ones so that the first fall opens a frame.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            fcnt        <= '1;
            lrclk       <= 1'b0;
            frame_start <= 1'b0;
        end else if (fall_tick) begin
            fcnt        <= fcnt_n;
            lrclk       <= fcnt_n[FC_W-1];
            frame_start <= (fcnt_n == '0);
        end else begin
            frame_start <= 1'b0;
        end
    end

endmodule

// File: rtl/sclk_master_gen.sv
module sclk_master_gen
    import sclk_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = 64
) (
    input  logic       mclk,
    input  logic       rst,
    input  logic [1:0] ratio_sel,
    input  logic       hi_rate,
    output logic       bclk,
    output logic       lrclk,
    output logic       bclk_fall,
    output logic       frame_start,
    output logic       cfg_err
);

    localparam int unsigned MAX_DIV = RATIO_MAX / BITS_PER_FRAME;
    localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

    logic             restart;
    logic             run;
    logic             fall_tick;
    logic [CNT_W-1:0] div;

    sclk_cfg_track #(
        .BITS_PER_FRAME(BITS_PER_FRAME),
        .CNT_W         (CNT_W)
    ) u_cfg (
        .clk    (mclk),
        .rst    (rst),
        .sel_in (ratio_sel),
        .fast_in(hi_rate),
        .restart(restart),
        .run    (run),
        .err    (cfg_err),
        .div    (div)
    );

    sclk_bit_div #(
        .CNT_W(CNT_W)
    ) u_bit (
        .clk      (mclk),
        .rst      (rst),
        .run      (run),
        .div      (div),
        .fall_tick(fall_tick),
        .bclk     (bclk),
        .bclk_fall(bclk_fall)
    );

    sclk_frame_div #(
        .BITS_PER_FRAME(BITS_PER_FRAME)
    ) u_frame (
        .clk        (mclk),
        .rst        (rst),
        .run        (run),
        .fall_tick  (fall_tick),
        .lrclk      (lrclk),
        .frame_start(frame_start)
    );

endmodule

// File: rtl/sclk_master_gen_chk.sv
module sclk_master_gen_chk (
    input logic       mclk,
    input logic       rst,
    input logic [1:0] ratio_sel,
    input logic       hi_rate,
    input logic       bclk,
    input logic       lrclk,
    input logic       bclk_fall,
    input logic       frame_start,
    input logic       cfg_err
);

    // R5
    fall_strobe_edge_chk: assert property (@(posedge mclk) disable iff (rst)
        bclk_fall |-> ($past(bclk) && !bclk));

    // R6
    lr_rise_aligned_chk: assert property (@(posedge mclk) disable iff (rst)
        $rose(lrclk) |-> bclk_fall);

    // R7
    frame_start_aligned_chk: assert property (@(posedge mclk) disable iff (rst)
        frame_start |-> (bclk_fall && !lrclk));

    // R2
    illegal_idle_chk: assert property (@(posedge mclk) disable iff (rst)
        cfg_err |-> (!bclk && !lrclk && !bclk_fall && !frame_start));

    // R3
    fast_range_err_chk: assert property (@(posedge mclk) disable iff (rst)
        (hi_rate && ratio_sel != 2'b00 && $past(hi_rate)
         && $past(ratio_sel) == ratio_sel) |-> cfg_err);

    // R8
    change_restart_chk: assert property (@(posedge mclk) disable iff (rst)
        (ratio_sel != $past(ratio_sel) || hi_rate != $past(hi_rate))
        |=> (!bclk && !lrclk));

endmodule

bind sclk_master_gen sclk_master_gen_chk u_chk (.*);

// File: tb/tb_sclk_master_gen.sv
module tb_sclk_master_gen;

    localparam int CLK_PERIOD = 10;

    // {sel[1:0], hi_rate, expected err, expected master cycles per bit clock[3:0]}
    localparam logic [7:0] VEC [9] = '{
        8'b01_0_0_1000,
        8'b10_0_0_0110,
        8'b00_0_0_0100,
        8'b11_0_1_0000,
        8'b00_1_0_0100,
        8'b10_1_1_0000,
        8'b01_1_1_0000,
        8'b11_1_1_0000,
        8'b10_0_0_0110
    };

    logic       mclk = 1'b0;
    logic       rst  = 1'b1;
    logic [1:0] ratio_sel = 2'b00;
    logic       hi_rate = 1'b0;
    logic       bclk, lrclk, bclk_fall, frame_start, cfg_err;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) mclk = ~mclk;

    sclk_master_gen dut (
        .mclk       (mclk),
        .rst        (rst),
        .ratio_sel  (ratio_sel),
        .hi_rate    (hi_rate),
        .bclk       (bclk),
        .lrclk      (lrclk),
        .bclk_fall  (bclk_fall),
        .frame_start(frame_start),
        .cfg_err    (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // One master edge passes; the caller is left at the following falling edge.
    task automatic step();
        @(negedge mclk);
    endtask

    task automatic count_to_fall(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!bclk_fall && n < 2000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat;
        int outs;

        // R9: state while reset is held
        repeat (3) step();
        outs = {28'd0, bclk, lrclk, bclk_fall, frame_start} | (cfg_err ? 16 : 0);
        check(outs == 0, "R9", "outputs during reset", outs, 0);
        rst = 1'b0;
        count_to_fall(lat);
        // R9 / R1: default ratio gives the first fall on edge 4
        check(lat == 4, "R9", "edges to first fall after reset", lat, 4);
        check(frame_start && !lrclk, "R7", "frame start at first fall",
              {frame_start, lrclk}, 2);

        for (int i = 0; i < 9; i++) begin
            logic [7:0] v;
            int n;
            int exp_err;
            string ereq;
            v         = VEC[i];
            ratio_sel = v[7:6];
            hi_rate   = v[5];
            exp_err   = v[4];
            n         = v[3:0];
            ereq      = (exp_err == 0) ? "R1" : ((v[7:6] == 2'b11) ? "R2" : "R3");
            step();
            check(cfg_err == exp_err, ereq, "cfg_err one edge after change", cfg_err, exp_err);
            // R8: clocks cleared at the restart edge
            check(!bclk && !lrclk, "R8", "clocks after change", {bclk, lrclk}, 0);
            if (exp_err != 0) begin
                int act;
                act = 0;
                for (int c = 0; c < 200; c++) begin
                    step();
                    if (bclk || lrclk || bclk_fall || frame_start) act++;
                end
                check(act == 0, ereq, "activity while illegal", act, 0);
            end else begin
                int highs, falls, lrh, fsc, second, misalign;
                logic prev_lr;
                lat = 1;
                while (!frame_start && lat < 2000) begin
                    step();
                    lat++;
                end
                check(lat == n + 1, "R8", "edges to first frame start", lat, n + 1);
                check(bclk_fall && !bclk && !lrclk, "R5",
                      "fall strobe at frame start", {bclk_fall, bclk, lrclk}, 4);
                highs = 0; falls = 0; lrh = 0; fsc = 0; second = -1; misalign = 0;
                prev_lr = 1'b0;
                for (int c = 0; c < 64 * n; c++) begin
                    if (c > 0) step();
                    if (bclk) highs++;
                    if (lrclk) lrh++;
                    if (frame_start) fsc++;
                    if (bclk_fall) begin
                        falls++;
                        if (c > 0 && second < 0) second = c;
                    end
                    if (lrclk != prev_lr && !bclk_fall) misalign++;
                    prev_lr = lrclk;
                end
                check(second == n, "R1", "master cycles per bit clock", second, n);
                check(highs == 32 * n, "R4", "bclk high cycles per frame", highs, 32 * n);
                check(falls == 64, "R5", "falls per frame", falls, 64);
                check(lrh == 32 * n, "R6", "lrclk high cycles per frame", lrh, 32 * n);
                check(misalign == 0, "R6", "lrclk changes off a fall", misalign, 0);
                check(fsc == 1, "R7", "frame starts per frame", fsc, 1);
                step();
                check(frame_start && !lrclk, "R7", "next frame start",
                      {frame_start, lrclk}, 2);
            end
        end

        // R9: reset during an illegal setting clears the error flag
        ratio_sel = 2'b11;
        hi_rate   = 1'b1;
        step();
        step();
        check(cfg_err == 1, "R2", "error before reset", cfg_err, 1);
        rst = 1'b1;
        step();
        outs = {28'd0, bclk, lrclk, bclk_fall, frame_start} | (cfg_err ? 16 : 0);
        check(outs == 0, "R9", "outputs after mid-run reset", outs, 0);
        ratio_sel = 2'b00;
        hi_rate   = 1'b0;
        step();
        rst = 1'b0;
        count_to_fall(lat);
        check(lat == 4, "R9", "edges to first fall after second reset", lat, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule